// File: doc/BRIEF.md
# Nibble Expression Stack

This block is the operand stack of a small stack-oriented processor whose data path is four bits wide. The element on top of the stack is held in a dedicated register that the processor treats like an accumulator. Every element below it lives in a single-port-write, asynchronous-read storage array indexed by a stack pointer. The entry the pointer currently selects is the second element.

Each clock cycle the processor issues one operation: push a new nibble, pop the top, overwrite the top, or collapse the two top elements into one result. The top and second elements are always visible on output ports, so an external ALU can combine them in the same cycle. The ALU then returns its result through the write-data input together with the collapse operation. The pointer is also visible for inspection. It wraps around silently at both ends of the array.

Top module: `nibble_xstack`

## Requirements
- R1: While `rst` is high at a rising clock edge, the top register and the stack pointer are both cleared to zero.
- R2: Operation code 1 (push) moves the previous top value into the array at pointer+1, advances the pointer by one and loads `wdata` into the top. After the edge, `nos` equals the previous top value.
- R3: Operation code 2 (pop) loads the top from the entry the pointer selects and moves the pointer back by one.
- R4: Operation code 3 (replace) loads `wdata` into the top and leaves the pointer and `nos` unchanged.
- R5: Operation code 4 (collapse) loads `wdata` into the top and moves the pointer back by one, so the former second element is discarded and `nos` shows the former third element.
- R6: Operation code 0, and the unused codes 5, 6 and 7, leave the top, the pointer and `nos` unchanged.
- R7: The pointer counts modulo the array depth. A pop at pointer 0 gives the highest pointer value, and a push at the highest value gives 0. Neither case is flagged.
- R8: `nos` always shows, without a clock delay, the array entry the current pointer selects.
- R9: A sequence of pushes that fills the whole array, followed by pops, returns the pushed values in reverse order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 3 | Operation code (0 idle, 1 push, 2 pop, 3 replace, 4 collapse, 5..7 idle) |
| wdata | input | DATA_W | Value pushed, written over the top, or the ALU result for a collapse |
| tos | output | DATA_W | Top element |
| nos | output | DATA_W | Second element, read from the array at the pointer |
| sp | output | PTR_W | Current stack pointer |

## Verification
The bench builds the block with a 3-bit pointer, which gives an eight-entry array while keeping the data width at four bits. This puts both directions of pointer wraparound within a few cycles. It also lets the bench fill every array location and then drain it, which checks reverse-order recovery across the wrap point without thousands of cycles of pushes. The data path itself is exercised at its real width, so every nibble value the table uses is representable as it would be in the full-size configuration.

// File: rtl/nxs_pkg.sv
package nxs_pkg;

    typedef enum logic [2:0] {
        SOP_IDLE  = 3'd0,
        SOP_PUSH  = 3'd1,
        SOP_POP   = 3'd2,
        SOP_REPL  = 3'd3,
        SOP_CLPS  = 3'd4
    } stack_op_e;

    typedef enum logic [1:0] {
        PSTEP_HOLD = 2'd0,
        PSTEP_INC  = 2'd1,
        PSTEP_DEC  = 2'd2
    } ptr_step_e;

    typedef enum logic [1:0] {
        TSRC_HOLD  = 2'd0,
        TSRC_WDATA = 2'd1,
        TSRC_ARRAY = 2'd2
    } top_src_e;

    typedef struct packed {
        ptr_step_e step;
        top_src_e  src;
        logic      spill;
    } stack_ctl_t;

    function automatic stack_ctl_t decode_op(input logic [2:0] code);
        stack_ctl_t c;
        c.step  = PSTEP_HOLD;
        c.src   = TSRC_HOLD;
        c.spill = 1'b0;
        case (code)
            SOP_PUSH: begin
                c.step  = PSTEP_INC;
                c.src   = TSRC_WDATA;
                c.spill = 1'b1;
            end
            SOP_POP: begin
                c.step = PSTEP_DEC;
                c.src  = TSRC_ARRAY;
            end
            SOP_REPL: begin
                c.src = TSRC_WDATA;
            end
            SOP_CLPS: begin
                c.step = PSTEP_DEC;
                c.src  = TSRC_WDATA;
            end
            default: begin
                c.step  = PSTEP_HOLD;
                c.src   = TSRC_HOLD;
                c.spill = 1'b0;
            end
        endcase
        return c;
    endfunction

    function automatic logic is_idle(input logic [2:0] code);
        return (code == SOP_IDLE) || (code > SOP_CLPS);
    endfunction

endpackage

// File: rtl/nxs_ptr.sv
module nxs_ptr
    import nxs_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  ptr_step_e        step,
    output logic [PTR_W-1:0] sp,
    output logic [PTR_W-1:0] sp_up
);
    localparam logic [PTR_W-1:0] PTR_MAX = {PTR_W{1'b1}};

    logic [PTR_W-1:0] sp_q;
    logic [PTR_W-1:0] sp_down;

    assign sp_up   = sp_q + 1'b1;
    assign sp_down = sp_q - 1'b1;
    assign sp      = sp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= '0;
        end else begin
            case (step)
                PSTEP_INC: sp_q <= sp_up;
                PSTEP_DEC: sp_q <= sp_down;
                default:   sp_q <= sp_q;
            endcase
        end
    end

    AST_SP_WRAP_UP: assert property (@(posedge clk) disable iff (rst)
        (step == PSTEP_INC && sp_q == PTR_MAX) |=> (sp_q == '0)); // R7
    AST_SP_WRAP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (step == PSTEP_DEC && sp_q == '0) |=> (sp_q == PTR_MAX)); // R7

endmodule

// File: rtl/nxs_store.sv
module nxs_store #(
    parameter int DATA_W = 4,
    parameter int PTR_W  = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wval,
    input  logic [PTR_W-1:0]  raddr,
    output logic [DATA_W-1:0] rval
);
    localparam int DEPTH = 1 << PTR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wval;
        end
    end

    assign rval = cells[raddr];

endmodule

// File: rtl/nxs_top_reg.sv
module nxs_top_reg
    import nxs_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  top_src_e          src,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] below,
    output logic [DATA_W-1:0] top
);
    logic [DATA_W-1:0] top_q;
    logic [DATA_W-1:0] top_d;

    always_comb begin
        case (src)
            TSRC_WDATA: top_d = wdata;
            TSRC_ARRAY: top_d = below;
            default:    top_d = top_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign top = top_q;

endmodule

// File: rtl/nibble_xstack.sv
module nibble_xstack
    import nxs_pkg::*;
#(
    parameter int DATA_W = 4,
    parameter int PTR_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] tos,
    output logic [DATA_W-1:0] nos,
    output logic [PTR_W-1:0]  sp
);
    stack_ctl_t        ctl;
    logic [PTR_W-1:0]  sp_cur;
    logic [PTR_W-1:0]  sp_next_up;
    logic [DATA_W-1:0] top_cur;
    logic [DATA_W-1:0] below_cur;

    assign ctl = decode_op(op);

    nxs_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk   (clk),
        .rst   (rst),
        .step  (ctl.step),
        .sp    (sp_cur),
        .sp_up (sp_next_up)
    );

    nxs_store #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_store (
        .clk   (clk),
        .we    (ctl.spill),
        .waddr (sp_next_up),
        .wval  (top_cur),
        .raddr (sp_cur),
        .rval  (below_cur)
    );

    nxs_top_reg #(.DATA_W(DATA_W)) u_top (
        .clk   (clk),
        .rst   (rst),
        .src   (ctl.src),
        .wdata (wdata),
        .below (below_cur),
        .top   (top_cur)
    );

    assign tos = top_cur;
    assign nos = below_cur;
    assign sp  = sp_cur;

    AST_PUSH_SPILL: assert property (@(posedge clk) disable iff (rst)
        (op == SOP_PUSH) |=> (nos == $past(tos) && tos == $past(wdata))); // R2
    AST_POP_FILL: assert property (@(posedge clk) disable iff (rst)
        (op == SOP_POP) |=> (tos == $past(nos))); // R3
    AST_REPL_KEEP: assert property (@(posedge clk) disable iff (rst)
        (op == SOP_REPL) |=> (sp == $past(sp) && nos == $past(nos) && tos == $past(wdata))); // R4
    AST_CLPS_RESULT: assert property (@(posedge clk) disable iff (rst)
        (op == SOP_CLPS) |=> (tos == $past(wdata) && sp == PTR_W'($past(sp) - 1'b1))); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        is_idle(op) |=> ($stable(tos) && $stable(sp) && $stable(nos))); // R6

endmodule

// File: tb/sim_nibble_xstack.sv
module sim_nibble_xstack;
    localparam int DW = 4;
    localparam int PW = 3;
    localparam int NVEC = 8;

    logic          clk;
    logic          rst;
    logic [2:0]    op;
    logic [DW-1:0] wdata;
    logic [DW-1:0] tos;
    logic [DW-1:0] nos;
    logic [PW-1:0] sp;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    nibble_xstack #(.DATA_W(DW), .PTR_W(PW)) u0 (
        .clk(clk), .rst(rst), .op(op), .wdata(wdata),
        .tos(tos), .nos(nos), .sp(sp)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    // fields: op(3) wdata(4) exp_tos(4) exp_sp(3) exp_nos(4) nos_valid(1)
    localparam logic [18:0] VEC [NVEC] = '{
        {3'd1, 4'h5, 4'h5, 3'd1, 4'h0, 1'b1},
        {3'd1, 4'hA, 4'hA, 3'd2, 4'h5, 1'b1},
        {3'd1, 4'h3, 4'h3, 3'd3, 4'hA, 1'b1},
        {3'd3, 4'h7, 4'h7, 3'd3, 4'hA, 1'b1},
        {3'd4, 4'hC, 4'hC, 3'd2, 4'h5, 1'b1},
        {3'd0, 4'h9, 4'hC, 3'd2, 4'h5, 1'b1},
        {3'd6, 4'hF, 4'hC, 3'd2, 4'h5, 1'b1},
        {3'd2, 4'h1, 4'h5, 3'd1, 4'h0, 1'b1}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] o, input logic [DW-1:0] d);
        op = o;
        wdata = d;
        @(posedge clk);
        @(negedge clk);
        op = 3'd0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        op = 3'd0;
        wdata = '0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic string req_of(input logic [2:0] o);
        case (o)
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            default: return "R6";
        endcase
    endfunction

    initial begin
        rst = 1'b1;
        op = 3'd0;
        wdata = '0;
        @(negedge clk);
        do_reset();
        // R1: reset state
        check("R1", "tos", tos, 0);
        check("R1", "sp", sp, 0);

        // table walk over push, replace, collapse, idle codes and pop; nos checks cover R8
        for (int i = 0; i < NVEC; i++) begin
            logic [18:0] v;
            v = VEC[i];
            step(v[18:16], v[15:12]);
            check(req_of(v[18:16]), "tos", tos, v[11:8]);
            check(req_of(v[18:16]), "sp", sp, v[7:5]);
            if (v[0]) check("R8", "nos", nos, v[4:1]);
        end

        // R7: pop at pointer 0 wraps to highest value
        do_reset();
        step(3'd2, 4'h0);
        check("R7", "sp after pop at 0", sp, 7);
        // R7: push at highest value wraps to 0
        step(3'd1, 4'h2);
        check("R7", "sp after push at max", sp, 0);
        check("R7", "tos after wrapping push", tos, 2);

        // R1: reset in mid-use clears state again
        do_reset();
        check("R1", "tos after second reset", tos, 0);
        check("R1", "sp after second reset", sp, 0);

        // R9: fill all eight locations then drain
        for (int k = 1; k <= 8; k++) begin
            step(3'd1, DW'(k));
            check("R9", "tos while filling", tos, k);
            check("R9", "nos while filling", nos, k - 1);
        end
        check("R9", "sp after full fill", sp, 0);
        for (int k = 7; k >= 1; k--) begin
            step(3'd2, 4'h0);
            check("R9", "tos while draining", tos, k);
        end
        check("R9", "sp after draining", sp, 1);

        // R6: unused code 7 with nonzero data leaves everything alone
        step(3'd7, 4'hE);
        check("R6", "tos after code 7", tos, 1);
        check("R6", "sp after code 7", sp, 1);
        check("R6", "nos after code 7", nos, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule